// File: doc/BRIEF.md
# Serial Master Transfer Sequencer

This block sequences one master-mode transfer of up to four bytes on a two-wire serial bus. Software writes an 8-bit control word. When the trigger bit is set and no transfer is running, the sequencer walks through the requested bytes. For each byte it asks a lower-level byte engine for an address phase (start plus 7-bit target address) if the bus is not already held. It then asks for a data byte, and a stop where the mode calls for one. Every request is held until the engine acknowledges it, and the acknowledge carries a NACK flag plus any received byte.

The sequencer keeps the bus claimed across bytes in chained mode. It can also put a stop after every byte. It ends early on an address or data NACK and records how many bytes completed. It raises an interrupt on completion when that interrupt is enabled. A halt command written while the bus is held releases the bus with a stop and can raise its own interrupt. Transmit bytes come from a 32-bit input, and received bytes land in a 32-bit output. In both, byte i sits at bits 8i+7..8i.

Top module: `seqMaster`

## Requirements
- R1: A control write made while idle stores the written value with bit 0 forced to 0. Control fields: bit 0 trigger, bit 1 read, bit 2 chain, bit 3 stop-every-byte, bits 5:4 byte count minus one, bit 6 stored only, bit 7 halt. A write with bit 0 set starts a transfer. After reset the stored value is 0x00.
- R2: An address phase is requested (op code 0 = start) only while the bus is not claimed. It carries address bits 7:1 of `masterAddr` and the read bit.
- R3: A transfer moves count+1 bytes (op code 1 = data). Transmit byte i comes from `txData[8i+7:8i]`, and in read mode received byte i is stored to `rxData[8i+7:8i]`.
- R4: A stop (op code 2) follows each byte when stop-every-byte is set or chain is clear. Otherwise the bus stays claimed and the next byte goes out with no new address phase.
- R5: An address NACK ends the transfer with the error flag and the aborted flag set. A successful address phase clears both.
- R6: A data NACK sets the error and aborted flags and ends the transfer, with the bus still claimed.
- R7: At the end of a transfer `xferCount` equals the number of bytes acknowledged without NACK (0 to 4).
- R8: A write with bit 7 set while idle and the bus is claimed issues one stop and releases the bus. If `intEnable` and `intMask[3]` are both set it also sets the interrupt-active flag. When the bus is free, a halt without the trigger bit requests nothing.
- R9: A transfer ending with at least one byte sets the interrupt-active flag when `intEnable` and `intMask[0]` are both set. `irq` follows that flag. `irqAck` clears it, and a set in the same cycle wins over the clear.
- R10: `extStatus` reads 0x40 with the bus free and 0x50 with the bus claimed, with bit 0 holding the aborted flag. After reset it reads 0x40.
- R11: A control write made while a transfer or halt is in progress is ignored: the stored value does not change and no further bus operations follow.
- R12: A request stays asserted with a stable op code until the engine acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low reset |
| ctrlWrEn | input | 1 | control word write strobe |
| ctrlWrData | input | 8 | control word |
| masterAddr | input | 8 | target address in bits 7:1 |
| intEnable | input | 1 | global interrupt enable |
| intMask | input | 4 | bit 0 completion, bit 3 halt |
| irqAck | input | 1 | clears interrupt-active flag |
| txData | input | 32 | transmit bytes, byte i at 8i |
| reqValid | output | 1 | request to byte engine |
| reqOp | output | 2 | 0 start, 1 data, 2 stop |
| reqAddr | output | 7 | target address |
| reqRead | output | 1 | transfer direction |
| reqData | output | 8 | byte to send |
| ackValid | input | 1 | engine acknowledge |
| ackNack | input | 1 | NACK seen on this request |
| ackData | input | 8 | received byte |
| ctrlValue | output | 8 | stored control word |
| busy | output | 1 | transfer or halt in progress |
| errFlag | output | 1 | error flag |
| irqActive | output | 1 | interrupt-active flag |
| extStatus | output | 8 | bus state and aborted flag |
| xferCount | output | 3 | bytes completed |
| rxData | output | 32 | received bytes |
| irq | output | 1 | interrupt request |

## Verification
The end of a transfer can set the interrupt-active flag in the same cycle that software acknowledges the interrupt. The bench holds `irqAck` high for a whole completing transfer so that the two coincide at the final edge. It then expects the flag still set once `busy` drops, and cleared only after a later pulse of `irqAck`. A halt can also meet a claimed bus left behind by a data NACK or a chained transfer, and the bench judges that case by the single stop request and the bus state returning to 0x40.

// File: rtl/seqMasterPkg.sv
package seqMasterPkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_DATA  = 2'd1,
    OP_STOP  = 2'd2
  } busOp_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_STOP,
    ST_HALT
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchCtrl;
    logic addrOk;
    logic addrNack;
    logic dataOk;
    logic dataNack;
    logic stopDone;
    logic finish;
    logic haltDone;
  } seqStrobe_t;

endpackage

// File: rtl/seqCtrl.sv
module seqCtrl
  import seqMasterPkg::*;
#(
  parameter int BUF_BYTES = 4,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlWrEn,
  input  logic             wrTrigger,
  input  logic             wrHalt,
  input  logic             busClaimed,
  input  logic             stopEach,
  input  logic [IDX_W-1:0] lastIdx,
  input  logic             ackValid,
  input  logic             ackNack,
  output logic             reqValid,
  output logic [1:0]       reqOp,
  output logic             busy,
  output seqStrobe_t       stb,
  output logic [IDX_W-1:0] byteIdx,
  output logic [CNT_W-1:0] doneCount
);

  seqState_e state, nextState;
  logic [IDX_W-1:0] nextIdx;
  logic isLast;

  assign isLast = (byteIdx == lastIdx);

  always_comb begin
    stb       = '0;
    nextState = state;
    nextIdx   = byteIdx;
    doneCount = '0;
    case (state)
      ST_IDLE: begin
        if (ctrlWrEn) begin
          stb.latchCtrl = 1'b1;
          if (wrHalt && busClaimed) begin
            nextState = ST_HALT;
          end else if (wrTrigger) begin
            nextIdx   = '0;
            nextState = busClaimed ? ST_DATA : ST_ADDR;
          end
        end
      end
      ST_ADDR: begin
        if (ackValid) begin
          if (ackNack) begin
            stb.addrNack = 1'b1;
            stb.finish   = 1'b1;
            doneCount    = CNT_W'(byteIdx);
            nextState    = ST_IDLE;
          end else begin
            stb.addrOk = 1'b1;
            nextState  = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (ackValid) begin
          if (ackNack) begin
            stb.dataNack = 1'b1;
            stb.finish   = 1'b1;
            doneCount    = CNT_W'(byteIdx);
            nextState    = ST_IDLE;
          end else begin
            stb.dataOk = 1'b1;
            if (stopEach) begin
              nextState = ST_STOP;
            end else if (isLast) begin
              stb.finish = 1'b1;
              doneCount  = CNT_W'(byteIdx) + CNT_W'(1);
              nextState  = ST_IDLE;
            end else begin
              nextIdx = byteIdx + IDX_W'(1);
            end
          end
        end
      end
      ST_STOP: begin
        if (ackValid) begin
          stb.stopDone = 1'b1;
          if (isLast) begin
            stb.finish = 1'b1;
            doneCount  = CNT_W'(byteIdx) + CNT_W'(1);
            nextState  = ST_IDLE;
          end else begin
            nextIdx   = byteIdx + IDX_W'(1);
            nextState = ST_ADDR;
          end
        end
      end
      ST_HALT: begin
        if (ackValid) begin
          stb.haltDone = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteIdx <= '0;
    end else begin
      state   <= nextState;
      byteIdx <= nextIdx;
    end
  end

  always_comb begin
    case (state)
      ST_ADDR: reqOp = OP_START;
      ST_DATA: reqOp = OP_DATA;
      default: reqOp = OP_STOP;
    endcase
  end

  assign reqValid = (state != ST_IDLE);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/seqData.sv
module seqData
  import seqMasterPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 4,
  parameter int ADDR_W    = 7,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int BUF_W = DATA_W * BUF_BYTES
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [IDX_W-1:0]   byteIdx,
  input  logic [CNT_W-1:0]   doneCount,
  input  logic [DATA_W-1:0]  ctrlWrData,
  input  logic [ADDR_W-1:0]  targetAddr,
  input  logic               intEnable,
  input  logic               doneMask,
  input  logic               haltMask,
  input  logic               irqAck,
  input  logic [BUF_W-1:0]   txData,
  input  logic [DATA_W-1:0]  ackData,
  output logic [DATA_W-1:0]  ctrlValue,
  output logic               busClaimed,
  output logic               stopEach,
  output logic [IDX_W-1:0]   lastIdx,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic               reqRead,
  output logic [DATA_W-1:0]  reqData,
  output logic               errFlag,
  output logic               abortFlag,
  output logic               irqActive,
  output logic [CNT_W-1:0]   xferCount,
  output logic [BUF_W-1:0]   rxData
);

  logic irqSet;

  assign reqRead  = ctrlValue[1];
  assign stopEach = ctrlValue[3] | ~ctrlValue[2];
  assign lastIdx  = ctrlValue[4 +: IDX_W];
  assign reqAddr  = targetAddr;
  assign reqData  = txData[byteIdx * DATA_W +: DATA_W];

  assign irqSet = intEnable &
                  ((stb.finish & (doneCount != '0) & doneMask) |
                   (stb.haltDone & haltMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlValue  <= '0;
      busClaimed <= 1'b0;
      errFlag    <= 1'b0;
      abortFlag  <= 1'b0;
      irqActive  <= 1'b0;
      xferCount  <= '0;
    end else begin
      if (stb.latchCtrl) ctrlValue <= {ctrlWrData[DATA_W-1:1], 1'b0};
      if (stb.addrOk) busClaimed <= 1'b1;
      else if (stb.stopDone || stb.haltDone) busClaimed <= 1'b0;
      if (stb.addrOk) begin
        errFlag   <= 1'b0;
        abortFlag <= 1'b0;
      end else if (stb.addrNack || stb.dataNack) begin
        errFlag   <= 1'b1;
        abortFlag <= 1'b1;
      end
      if (stb.finish) xferCount <= doneCount;
      if (irqSet) irqActive <= 1'b1;
      else if (irqAck) irqActive <= 1'b0;
    end
  end

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_rxByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rxData[g*DATA_W +: DATA_W] <= '0;
      end else if (stb.dataOk && reqRead && (byteIdx == IDX_W'(g))) begin
        rxData[g*DATA_W +: DATA_W] <= ackData;
      end
    end
  end

endmodule

// File: rtl/seqMaster.sv
module seqMaster
  import seqMasterPkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 4,
  parameter int ADDR_W    = 7,
  localparam int IDX_W = $clog2(BUF_BYTES),
  localparam int CNT_W = $clog2(BUF_BYTES + 1),
  localparam int BUF_W = DATA_W * BUF_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [DATA_W-1:0] ctrlWrData,
  input  logic [ADDR_W:0]   masterAddr,
  input  logic              intEnable,
  input  logic [3:0]        intMask,
  input  logic              irqAck,
  input  logic [BUF_W-1:0]  txData,
  output logic              reqValid,
  output logic [1:0]        reqOp,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqRead,
  output logic [DATA_W-1:0] reqData,
  input  logic              ackValid,
  input  logic              ackNack,
  input  logic [DATA_W-1:0] ackData,
  output logic [DATA_W-1:0] ctrlValue,
  output logic              busy,
  output logic              errFlag,
  output logic              irqActive,
  output logic [7:0]        extStatus,
  output logic [CNT_W-1:0]  xferCount,
  output logic [BUF_W-1:0]  rxData,
  output logic              irq
);

  seqStrobe_t       stb;
  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] lastIdx;
  logic [CNT_W-1:0] doneCount;
  logic             busClaimed;
  logic             stopEach;
  logic             abortFlag;
  logic [3:0]       unusedBits;

  assign unusedBits = {masterAddr[0], intMask[2:1], 1'b0};

  seqCtrl #(.BUF_BYTES(BUF_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn),
    .wrTrigger(ctrlWrData[0]),
    .wrHalt(ctrlWrData[DATA_W-1]),
    .busClaimed(busClaimed),
    .stopEach(stopEach),
    .lastIdx(lastIdx),
    .ackValid(ackValid),
    .ackNack(ackNack),
    .reqValid(reqValid),
    .reqOp(reqOp),
    .busy(busy),
    .stb(stb),
    .byteIdx(byteIdx),
    .doneCount(doneCount)
  );

  seqData #(.DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN),
    .stb(stb),
    .byteIdx(byteIdx),
    .doneCount(doneCount),
    .ctrlWrData(ctrlWrData),
    .targetAddr(masterAddr[ADDR_W:1]),
    .intEnable(intEnable),
    .doneMask(intMask[0]),
    .haltMask(intMask[3]),
    .irqAck(irqAck),
    .txData(txData),
    .ackData(ackData),
    .ctrlValue(ctrlValue),
    .busClaimed(busClaimed),
    .stopEach(stopEach),
    .lastIdx(lastIdx),
    .reqAddr(reqAddr),
    .reqRead(reqRead),
    .reqData(reqData),
    .errFlag(errFlag),
    .abortFlag(abortFlag),
    .irqActive(irqActive),
    .xferCount(xferCount),
    .rxData(rxData)
  );

  assign extStatus = {4'b0100 | {3'b000, busClaimed}, 3'b000, abortFlag};
  assign irq       = irqActive;

endmodule

// File: rtl/seqMasterChk.sv
module seqMasterChk #(
  parameter int DATA_W    = 8,
  parameter int BUF_BYTES = 4,
  localparam int CNT_W = $clog2(BUF_BYTES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              ctrlWrEn,
  input logic              reqValid,
  input logic [1:0]        reqOp,
  input logic              ackValid,
  input logic              busy,
  input logic [DATA_W-1:0] ctrlValue,
  input logic [7:0]        extStatus,
  input logic [CNT_W-1:0]  xferCount,
  input logic              irq
);

  // R1
  trigger_not_stored_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlValue[0]);

  // R2
  start_on_free_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'd0) |-> !extStatus[4]);

  // R7
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferCount <= CNT_W'(BUF_BYTES));

  // R9
  irq_from_sequence_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(busy));

  // R11
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && ctrlWrEn) |=> $stable(ctrlValue));

  // R12
  request_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !ackValid) |=> (reqValid && $stable(reqOp)));

endmodule

bind seqMaster seqMasterChk #(.DATA_W(DATA_W), .BUF_BYTES(BUF_BYTES)) uChk (
  .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .reqValid(reqValid),
  .reqOp(reqOp), .ackValid(ackValid), .busy(busy), .ctrlValue(ctrlValue),
  .extStatus(extStatus), .xferCount(xferCount), .irq(irq)
);

// File: tb/seqMaster_test.sv
module seqMaster_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlWrEn = 1'b0;
  logic [7:0]  ctrlWrData = '0;
  logic [7:0]  masterAddr = 8'hA4;
  logic        intEnable = 1'b0;
  logic [3:0]  intMask = '0;
  logic        irqAck = 1'b0;
  logic [31:0] txData = 32'h44332211;
  logic        reqValid;
  logic [1:0]  reqOp;
  logic [6:0]  reqAddr;
  logic        reqRead;
  logic [7:0]  reqData;
  logic        ackValid = 1'b0;
  logic        ackNack = 1'b0;
  logic [7:0]  ackData = '0;
  logic [7:0]  ctrlValue;
  logic        busy;
  logic        errFlag;
  logic        irqActive;
  logic [7:0]  extStatus;
  logic [2:0]  xferCount;
  logic [31:0] rxData;
  logic        irq;

  int total = 0;
  int bad = 0;

  // byte engine model state
  logic [1:0] opLog [0:31];
  logic [7:0] sentLog [0:31];
  int opCount = 0;
  int dataOps = 0;
  int startOps = 0;
  int sentCount = 0;
  int nackStartAt = -1;
  int nackDataAt = -1;
  logic [6:0] lastAddr = '0;
  logic lastRead = 1'b0;

  seqMaster uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (ackValid) begin
      ackValid = 1'b0;
      ackNack  = 1'b0;
    end else if (reqValid) begin
      if (opCount < 32) opLog[opCount] = reqOp;
      opCount++;
      ackNack = 1'b0;
      if (reqOp == 2'd0) begin
        lastAddr = reqAddr;
        lastRead = reqRead;
        if (startOps == nackStartAt) ackNack = 1'b1;
        startOps++;
      end else if (reqOp == 2'd1) begin
        if (!reqRead && sentCount < 32) begin
          sentLog[sentCount] = reqData;
          sentCount++;
        end
        ackData = 8'hA0 + 8'(dataOps);
        if (dataOps == nackDataAt) ackNack = 1'b1;
        dataOps++;
      end
      ackValid = 1'b1;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    opCount = 0; dataOps = 0; startOps = 0; sentCount = 0;
    nackStartAt = -1; nackDataAt = -1;
  endtask

  task automatic writeCtrl(logic [7:0] v);
    @(negedge clk);
    ctrlWrData = v;
    ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (n >= 200) begin
      total++; bad++;
      $display("FAIL watchdog busy stuck actual=1 expected=0");
    end
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic checkOps(string req, string pattern);
    check({req, " op count"}, 32'(opCount), 32'(pattern.len()));
    for (int i = 0; i < pattern.len() && i < 32; i++) begin
      logic [1:0] e;
      e = (pattern[i] == "S") ? 2'd0 : (pattern[i] == "D") ? 2'd1 : 2'd2;
      check({req, " op order"}, 32'(opLog[i]), 32'(e));
    end
  endtask

  task automatic testReset();
    check("R1 reset ctrl", 32'(ctrlValue), 32'h00);
    check("R10 reset ext", 32'(extStatus), 32'h40);
    check("R7 reset count", 32'(xferCount), 0);
    check("R9 reset irq", 32'(irq), 0);
    check("R12 reset req", 32'(reqValid), 0);
  endtask

  task automatic testWriteFour();
    clearLog();
    intEnable = 1'b1; intMask = 4'b0001;
    writeCtrl(8'h31);
    waitIdle();
    checkOps("R4 nochain", "SDPSDPSDPSDP");
    check("R1 stored", 32'(ctrlValue), 32'h30);
    check("R2 addr", 32'(lastAddr), 32'h52);
    check("R2 dir", 32'(lastRead), 0);
    for (int i = 0; i < 4; i++) check("R3 tx byte", 32'(sentLog[i]), 32'(txData[i*8 +: 8]));
    check("R7 count 4", 32'(xferCount), 4);
    check("R9 done irq", 32'(irq), 1);
    check("R10 free", 32'(extStatus), 32'h40);
    pulseAck();
    check("R9 ack clears", 32'(irqActive), 0);
  endtask

  task automatic testChainRead();
    clearLog();
    intEnable = 1'b1; intMask = 4'b0000;
    writeCtrl(8'h27);
    waitIdle();
    checkOps("R4 chain", "SDDD");
    check("R2 read dir", 32'(lastRead), 1);
    check("R3 rx bytes", rxData[23:0], 32'h00A2A1A0);
    check("R7 count 3", 32'(xferCount), 3);
    check("R9 masked", 32'(irq), 0);
    check("R10 claimed", 32'(extStatus), 32'h50);
  endtask

  task automatic testHaltClaimed();
    clearLog();
    intEnable = 1'b1; intMask = 4'b1000;
    writeCtrl(8'h80);
    waitIdle();
    checkOps("R8 halt", "P");
    check("R8 released", 32'(extStatus), 32'h40);
    check("R8 halt irq", 32'(irq), 1);
    pulseAck();
    check("R9 ack after halt", 32'(irq), 0);
  endtask

  task automatic testHaltFree();
    clearLog();
    writeCtrl(8'h80);
    repeat (3) @(negedge clk);
    check("R8 free halt no op", 32'(opCount), 0);
    check("R1 halt stored", 32'(ctrlValue), 32'h80);
  endtask

  task automatic testRepeatedStart();
    clearLog();
    intMask = 4'b0000;
    writeCtrl(8'h1D);
    waitIdle();
    checkOps("R4 stop each", "SDPSDP");
    check("R7 count 2", 32'(xferCount), 2);
    check("R3 rx byte1", rxData[15:8], 32'hA1);
  endtask

  task automatic testAddrNack();
    clearLog();
    nackStartAt = 0;
    intEnable = 1'b1; intMask = 4'b0001;
    writeCtrl(8'h11);
    waitIdle();
    checkOps("R5 addr nack", "S");
    check("R5 err", 32'(errFlag), 1);
    check("R5 aborted", 32'(extStatus), 32'h41);
    check("R7 count 0", 32'(xferCount), 0);
    check("R9 no irq on zero", 32'(irq), 0);
  endtask

  task automatic testDataNack();
    clearLog();
    nackDataAt = 2;
    intMask = 4'b0000;
    writeCtrl(8'h31);
    waitIdle();
    checkOps("R6 data nack", "SDPSDPSD");
    check("R6 err", 32'(errFlag), 1);
    check("R6 claimed aborted", 32'(extStatus), 32'h51);
    check("R7 partial", 32'(xferCount), 2);
    clearLog();
    writeCtrl(8'h80);
    waitIdle();
    checkOps("R8 halt after nack", "P");
    clearLog();
    writeCtrl(8'h01);
    waitIdle();
    check("R5 err cleared", 32'(errFlag), 0);
    check("R5 aborted cleared", 32'(extStatus), 32'h40);
  endtask

  task automatic testBusyWrite();
    clearLog();
    writeCtrl(8'h01);
    @(negedge clk);
    ctrlWrData = 8'h33; ctrlWrEn = 1'b1;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    waitIdle();
    repeat (3) @(negedge clk);
    check("R11 ctrl kept", 32'(ctrlValue), 32'h00);
    checkOps("R11 no extra ops", "SDP");
  endtask

  task automatic testAckCollide();
    clearLog();
    intEnable = 1'b1; intMask = 4'b0001;
    @(negedge clk); irqAck = 1'b1;
    writeCtrl(8'h01);
    waitIdle();
    check("R9 set wins", 32'(irqActive), 1);
    irqAck = 1'b0;
    @(negedge clk);
    check("R9 held", 32'(irq), 1);
    pulseAck();
    check("R9 cleared", 32'(irq), 0);
    clearLog();
    intEnable = 1'b0;
    writeCtrl(8'h01);
    waitIdle();
    check("R9 disabled", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWriteFour();
    testChainRead();
    testHaltClaimed();
    testHaltFree();
    testRepeatedStart();
    testAddrNack();
    testDataNack();
    testBusyWrite();
    testAckCollide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule